// File: doc/BRIEF.md
# Modem Status Register

This block keeps the modem status register of a 16550-compatible serial port. It watches four asynchronous modem lines (clear-to-send, data-set-ready, ring indicator and carrier detect) and brings each one into the clock domain through a synchronizer chain. It keeps the current level of each line in the upper nibble of the register and a sticky change flag for each line in the lower nibble. The ring indicator flag records only the end of a ring, when the line falls from 1 to 0.

Software reads the register with a one-cycle read strobe. The value presented in that cycle is the read data. On the following edge the four change flags are cleared, except for a change that is detected on that same edge, which is kept. A read that finds no change flag set leaves the register unchanged. In loopback mode the four status bits come from the modem control outputs instead of the pins: RTS feeds CTS, DTR feeds DSR, OUT1 feeds RI and OUT2 feeds DCD. The pins are then ignored. A single output, high while any change flag is set, feeds the modem status source of the interrupt logic.

All pins are plain control and status signals. No valid/ready handshake is used, because the register is always readable and nothing can apply back-pressure.

Top module: `modem_status_unit`

## Requirements
- R1: After reset the register reads 0xB0 (DCD, DSR and CTS high, RI low, no change flags), and `delta_any` is low.
- R2: Register bit 7 is DCD, bit 6 is RI, bit 5 is DSR and bit 4 is CTS. Outside loopback, a pin change shows in the register on the third rising edge after it is driven: two synchronizer stages and then the status register.
- R3: A change in either direction on CTS, DSR or DCD sets its change flag: bit 0 for CTS, bit 1 for DSR, bit 3 for DCD.
- R4: Bit 2 is set only when RI falls from 1 to 0. A rising RI leaves bit 2 unchanged.
- R5: Change flags are sticky. They stay set until a read, so a line that toggles twice still shows its flag.
- R6: When `rd_stb` is high for a cycle, bits 3:0 are zero after the next edge and bits 7:4 are unaffected. A read with no flag set leaves the value unchanged.
- R7: A change detected on the same edge that clears a read keeps its flag set. Flags from before the read are cleared.
- R8: With `loop_en` high, the status bits become RTS→bit 4, DTR→bit 5, OUT1→bit 6 and OUT2→bit 7 one edge after the control input is driven. These changes set the change flags under the same rules as R3 and R4, including when the block enters or leaves loopback.
- R9: In loopback, the external modem pins have no effect on the register.
- R10: `delta_any` is high exactly when any of bits 3:0 of `msr_q` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_cts | input | 1 | Clear-to-send pin, asynchronous |
| pin_dsr | input | 1 | Data-set-ready pin, asynchronous |
| pin_ri | input | 1 | Ring indicator pin, asynchronous |
| pin_dcd | input | 1 | Carrier detect pin, asynchronous |
| loop_en | input | 1 | Loopback mode select |
| ctl_dtr | input | 1 | Modem control DTR output |
| ctl_rts | input | 1 | Modem control RTS output |
| ctl_out1 | input | 1 | Modem control OUT1 output |
| ctl_out2 | input | 1 | Modem control OUT2 output |
| rd_stb | input | 1 | One-cycle register read strobe |
| msr_q | output | 8 | Register value: line levels in 7:4, change flags in 3:0 |
| delta_any | output | 1 | Any change flag set, to the interrupt logic |

## Verification
The clearing of the flags by a read and the setting of a flag by a new line change can land on the same clock edge. The bench provokes this in loopback, where the latency is a single edge. It first leaves a DSR flag pending. It then drives `rd_stb` and a change of RTS in the same cycle, and expects the next value to hold the new CTS flag with the old DSR flag gone. A scoreboard holds the expected register value and `delta_any` for each cycle in which they are predicted to change, and so also checks the three-edge pin latency and that nothing changes before it has elapsed.

// File: rtl/msr_pkg.sv
package msr_pkg;

  // Order mirrors the register nibbles: bit 3 of the nibble is carrier detect.
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } modem_lines_t;

  typedef struct packed {
    logic ddcd;
    logic teri;
    logic ddsr;
    logic dcts;
  } modem_delta_t;

  localparam int unsigned LINE_CNT = $bits(modem_lines_t);

  // Idle level of the lines after reset: carrier, data-set-ready and
  // clear-to-send high, ring low.
  localparam modem_lines_t LINES_IDLE = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b1};

endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[LAST];

endmodule

// File: rtl/msr_src_mux.sv
module msr_src_mux
  import msr_pkg::*;
(
  input  logic         loop_en,
  input  modem_lines_t pins_i,
  input  logic         ctl_dtr,
  input  logic         ctl_rts,
  input  logic         ctl_out1,
  input  logic         ctl_out2,
  output modem_lines_t lines_o
);

  modem_lines_t looped;

  always_comb begin
    looped.cts = ctl_rts;
    looped.dsr = ctl_dtr;
    looped.ri  = ctl_out1;
    looped.dcd = ctl_out2;
    lines_o    = loop_en ? looped : pins_i;
  end

endmodule

// File: rtl/msr_track.sv
module msr_track
  import msr_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  modem_lines_t lines_i,
  input  logic         rd_stb,
  output modem_lines_t status_o,
  output modem_delta_t delta_o
);

  modem_lines_t st_q;
  modem_delta_t d_q, chg, keep, d_nxt;

  always_comb begin
    chg.dcts = st_q.cts ^ lines_i.cts;
    chg.ddsr = st_q.dsr ^ lines_i.dsr;
    chg.ddcd = st_q.dcd ^ lines_i.dcd;
    chg.teri = st_q.ri & ~lines_i.ri;      // trailing edge only
    keep     = rd_stb ? '0 : d_q;
    d_nxt    = keep | chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= LINES_IDLE;
      d_q  <= '0;
    end else begin
      st_q <= lines_i;
      d_q  <= d_nxt;
    end
  end

  assign status_o = st_q;
  assign delta_o  = d_q;

  // R4
  ri_rise_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $rose(st_q.ri) && !$past(d_q.teri) |-> !d_q.teri);

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(rd_stb) |-> ((d_q & $past(d_q)) == $past(d_q)));

  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(rd_stb) && $stable(st_q) |-> (d_q == '0));

  // R3
  cts_change_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$stable(st_q.cts) |-> d_q.dcts);

endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
  import msr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_cts,
  input  logic       pin_dsr,
  input  logic       pin_ri,
  input  logic       pin_dcd,
  input  logic       loop_en,
  input  logic       ctl_dtr,
  input  logic       ctl_rts,
  input  logic       ctl_out1,
  input  logic       ctl_out2,
  input  logic       rd_stb,
  output logic [7:0] msr_q,
  output logic       delta_any
);

  modem_lines_t pins_raw, pins_sync, lines;
  modem_lines_t status;
  modem_delta_t delta;

  always_comb begin
    pins_raw.cts = pin_cts;
    pins_raw.dsr = pin_dsr;
    pins_raw.ri  = pin_ri;
    pins_raw.dcd = pin_dcd;
  end

  msr_sync #(
    .WIDTH   (LINE_CNT),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (LINES_IDLE)
  ) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pins_raw),
    .sync_o  (pins_sync)
  );

  msr_src_mux i_mux (
    .loop_en  (loop_en),
    .pins_i   (pins_sync),
    .ctl_dtr  (ctl_dtr),
    .ctl_rts  (ctl_rts),
    .ctl_out1 (ctl_out1),
    .ctl_out2 (ctl_out2),
    .lines_o  (lines)
  );

  msr_track i_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines_i  (lines),
    .rd_stb   (rd_stb),
    .status_o (status),
    .delta_o  (delta)
  );

  assign msr_q     = {status, delta};
  assign delta_any = |delta;

  // R8
  loop_rts_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(loop_en) |-> (msr_q[4] == $past(ctl_rts)));

  // R8
  loop_out2_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(loop_en) |-> (msr_q[7] == $past(ctl_out2)));

endmodule

// File: tb/test_modem_status_unit.sv
module test_modem_status_unit;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_cts = 1'b1, pin_dsr = 1'b1, pin_ri = 1'b0, pin_dcd = 1'b1;
  logic loop_en = 1'b0;
  logic ctl_dtr = 1'b0, ctl_rts = 1'b0, ctl_out1 = 1'b0, ctl_out2 = 1'b0;
  logic rd_stb = 1'b0;
  logic [7:0] msr_q;
  logic delta_any;

  int cyc = 0;
  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  typedef struct {
    int         at;
    logic [7:0] val;
    logic       dp;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  exp_t mon_e;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  modem_status_unit i_modem_status_unit (
    .clk(clk), .rst_n(rst_n),
    .pin_cts(pin_cts), .pin_dsr(pin_dsr), .pin_ri(pin_ri), .pin_dcd(pin_dcd),
    .loop_en(loop_en),
    .ctl_dtr(ctl_dtr), .ctl_rts(ctl_rts), .ctl_out1(ctl_out1), .ctl_out2(ctl_out2),
    .rd_stb(rd_stb), .msr_q(msr_q), .delta_any(delta_any)
  );

  task automatic push(input int dly, input logic [7:0] v, input string tag);
    exp_t e;
    e.at = cyc + dly; e.val = v; e.dp = |v[3:0]; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input logic [7:0] after, input string tag);
    rd_stb = 1'b1;
    push(1, after, tag);
    wait_n(1);
    rd_stb = 1'b0;
    wait_n(1);
  endtask

  // Monitor: compares the register and delta_any at each predicted cycle.
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
      mon_e = sb_q.pop_front();
      n_checks++;
      if (mon_e.at < cyc) begin
        n_errors++;
        $display("FAIL %s: expectation for cycle %0d missed (actual cycle %0d, expected cycle %0d)",
                 mon_e.tag, mon_e.at, cyc, mon_e.at);
      end else if (msr_q !== mon_e.val || delta_any !== mon_e.dp) begin
        n_errors++;
        $display("FAIL %s: cycle %0d msr actual %02h expected %02h, delta_any actual %0b expected %0b",
                 mon_e.tag, cyc, msr_q, mon_e.val, delta_any, mon_e.dp);
      end
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    push(1, 8'hB0, "R1 reset value");
    wait_n(2);

    // R2 latency and layout, R3 CTS flag
    pin_cts = 1'b0;
    push(2, 8'hB0, "R2 no change before third edge");
    push(3, 8'hA1, "R2 R3 CTS low sets bit 0");
    wait_n(4);
    do_read(8'hA0, "R6 read clears flags");

    // R4 ring indicator
    pin_ri = 1'b1;
    push(3, 8'hE0, "R4 rising RI no flag");
    wait_n(4);
    pin_ri = 1'b0;
    push(3, 8'hA4, "R4 falling RI sets bit 2");
    wait_n(4);
    do_read(8'hA0, "R6 clear after RI");

    // R5 sticky flags across a double toggle
    pin_dcd = 1'b0;
    push(3, 8'h28, "R3 DCD low sets bit 3");
    wait_n(4);
    pin_dcd = 1'b1;
    push(3, 8'hA8, "R5 flag stays after second toggle");
    wait_n(4);
    do_read(8'hA0, "R6 clear after DCD");
    do_read(8'hA0, "R6 read with no flag unchanged");

    // R8 enter loopback with all control outputs low
    loop_en = 1'b1;
    push(1, 8'h0A, "R8 enter loopback flags DCD and DSR");
    wait_n(1);
    do_read(8'h00, "R6 clear in loopback");

    // R9 pins ignored in loopback
    pin_cts = 1'b1;
    pin_ri  = 1'b1;
    push(4, 8'h00, "R9 pins ignored in loopback");
    wait_n(5);
    pin_ri = 1'b0;
    push(4, 8'h00, "R9 RI pin fall ignored");
    wait_n(5);

    ctl_rts = 1'b1;
    push(1, 8'h11, "R8 RTS to bit 4");
    wait_n(1);
    do_read(8'h10, "R6 clear");
    ctl_dtr = 1'b1;
    push(1, 8'h32, "R8 DTR to bit 5");
    wait_n(1);
    do_read(8'h30, "R6 clear");
    ctl_out1 = 1'b1;
    push(1, 8'h70, "R8 OUT1 to bit 6 R4 rising no flag");
    wait_n(1);
    ctl_out1 = 1'b0;
    push(1, 8'h34, "R8 R4 OUT1 fall sets bit 2");
    wait_n(1);
    do_read(8'h30, "R6 clear");
    ctl_out2 = 1'b1;
    push(1, 8'hB8, "R8 OUT2 to bit 7");
    wait_n(1);
    do_read(8'hB0, "R6 clear");

    // R7 read and a new change on the same edge
    ctl_dtr = 1'b0;
    push(1, 8'h92, "R8 DTR fall sets bit 1");
    wait_n(1);
    rd_stb  = 1'b1;
    ctl_rts = 1'b0;
    push(1, 8'h81, "R7 new CTS flag kept, old DSR flag cleared");
    wait_n(1);
    rd_stb = 1'b0;
    wait_n(1);
    do_read(8'h80, "R6 R10 clear leaves delta_any low");

    // R8 leave loopback: synchronized pins are cts=1 dsr=1 ri=0 dcd=1
    loop_en = 1'b0;
    push(1, 8'hB3, "R8 leave loopback flags DSR and CTS");
    wait_n(1);
    do_read(8'hB0, "R10 delta_any low after clear");

    wait_n(3);
    if (sb_q.size() != 0) begin
      n_checks++;
      n_errors++;
      $display("FAIL scoreboard: actual %0d pending expectations, expected 0", sb_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

endmodule